// File: doc/BRIEF.md
# Programmable-Level DMA Channel Arbiter

This block chooses which of a set of DMA channels may move data next. Each channel offers a request bit, an enable bit and a two-bit level that software programs. When the arbiter is free, it picks one channel that is both enabled and requesting. It prefers the highest level, and when levels are equal it prefers the lowest channel number. It then holds that channel's grant until the channel reports that it has finished one block.

When the block-done strobe arrives, the arbiter decides again in the same clock edge, using the requests, enables and levels present at that moment. The same channel may win again. Levels are read only at those decision points, so changing a level in the middle of a block does not move the grant. The grant is given as a one-hot vector and as an encoded index, along with a busy flag.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, `grant` is all zeros, `grant_idx` is 0 and `busy` is 0.
- R2: A channel takes part in a decision only when both its `req` bit and its `en` bit are 1. A channel with only one of the two set is never granted.
- R3: Channel i's level is `prio[2i+1:2i]`, with 00 the lowest level, then 01, then 10, and 11 the highest. Among the eligible channels, the one with the highest level is granted.
- R4: When several eligible channels share the highest level, the one with the smallest channel number is granted.
- R5: While idle, a decision is made at every clock edge. If an eligible channel is present at an edge, the grant and `busy` appear right after that edge.
- R6: While busy and `blk_done` is 0, `grant` and `grant_idx` stay unchanged. This holds whatever happens to `req`, `en` or `prio`.
- R7: At a clock edge where `busy` is 1 and `blk_done` is 1, a new decision is made from the current inputs and takes effect right after that edge. The previous holder may win again.
- R8: If a decision finds no eligible channel, `grant` becomes all zeros, `grant_idx` becomes 0 and `busy` becomes 0.
- R9: While busy, `grant` has exactly one bit set, at position `grant_idx`. While idle, `grant` is zero.
- R10: `blk_done` has no effect while idle. An idle arbiter with no eligible channel stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_CH | Per-channel service request |
| en | input | NUM_CH | Per-channel enable |
| prio | input | NUM_CH*PRIO_W | Packed per-channel levels, channel i at bits [PRIO_W*i +: PRIO_W] |
| blk_done | input | 1 | Strobe from the granted channel marking the end of its block |
| grant | output | NUM_CH | One-hot grant |
| grant_idx | output | $clog2(NUM_CH) | Index of the granted channel |
| busy | output | 1 | A channel currently holds the grant |

## Verification
A wrong comparison or tie-break shows as the wrong `grant_idx` one edge after a decision point. Every decision is compared with a model of the level-then-number rule. A grant that fails to hold shows as a changed `grant_idx` within one cycle of changing the levels or requests in the middle of a block. A missed idle transition, or a decision made at the wrong time, shows at `busy` on the very next edge, because the bench samples every decision exactly one cycle after the edge that causes it.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   // selects the structure of the winner search
   typedef enum logic [0:0] {
      PICK_TREE = 1'b0,
      PICK_SCAN = 1'b1
   } pick_style_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/dma_arb_qualify.sv
// Builds a comparison key per channel: {eligible, level}; zero when not eligible.
module dma_arb_qualify #(
   parameter int unsigned NUM_CH = 12,
   parameter int unsigned PRIO_W = 2,
   localparam int unsigned KEY_W = PRIO_W + 1
) (
   input  logic [NUM_CH-1:0]        req,
   input  logic [NUM_CH-1:0]        en,
   input  logic [NUM_CH*PRIO_W-1:0] prio,
   output logic [NUM_CH*KEY_W-1:0]  keys,
   output logic                     any_elig
);

   logic [NUM_CH-1:0] elig;

   assign elig     = req & en;
   assign any_elig = |elig;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_key
      assign keys[c*KEY_W +: KEY_W] =
         elig[c] ? {1'b1, prio[c*PRIO_W +: PRIO_W]} : '0;
   end

endmodule

// File: rtl/dma_arb_pick.sv
// Finds the largest key; on equal keys the lower channel number wins.
module dma_arb_pick
   import dma_arb_pkg::*;
#(
   parameter int unsigned NUM_CH     = 12,
   parameter int unsigned PRIO_W     = 2,
   parameter pick_style_e PICK_STYLE = PICK_TREE,
   localparam int unsigned KEY_W  = PRIO_W + 1,
   localparam int unsigned IDX_W  = idx_width(NUM_CH),
   localparam int unsigned LEAVES = 1 << IDX_W
) (
   input  logic [NUM_CH*KEY_W-1:0] keys,
   output logic [IDX_W-1:0]        win_idx,
   output logic                    win_valid
);

   if (PICK_STYLE == PICK_TREE) begin : g_tree
      // heap layout: node n has children 2n+1 (lower numbers) and 2n+2
      logic [KEY_W-1:0] node_key [2*LEAVES-1];
      logic [IDX_W-1:0] node_idx [2*LEAVES-1];

      for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
         if (j < NUM_CH) begin : g_real
            assign node_key[LEAVES-1+j] = keys[j*KEY_W +: KEY_W];
         end else begin : g_pad
            assign node_key[LEAVES-1+j] = '0;
         end
         assign node_idx[LEAVES-1+j] = IDX_W'(j);
      end

      for (genvar n = 0; n < LEAVES-1; n++) begin : g_node
         logic take_left;
         assign take_left   = node_key[2*n+1] >= node_key[2*n+2];
         assign node_key[n] = take_left ? node_key[2*n+1] : node_key[2*n+2];
         assign node_idx[n] = take_left ? node_idx[2*n+1] : node_idx[2*n+2];
      end

      assign win_idx   = node_key[0][KEY_W-1] ? node_idx[0] : '0;
      assign win_valid = node_key[0][KEY_W-1];
   end else begin : g_scan
      logic [KEY_W-1:0] best_key;
      logic [IDX_W-1:0] best_idx;

      always_comb begin
         best_key = '0;
         best_idx = '0;
         for (int i = NUM_CH-1; i >= 0; i--) begin
            if (keys[i*KEY_W +: KEY_W] >= best_key) begin
               best_key = keys[i*KEY_W +: KEY_W];
               best_idx = IDX_W'(i);
            end
         end
      end

      assign win_idx   = best_key[KEY_W-1] ? best_idx : '0;
      assign win_valid = best_key[KEY_W-1];
   end

endmodule

// File: rtl/dma_arb_hold.sv
// Holds the grant for a block; reloads when idle or on block completion.
module dma_arb_hold #(
   parameter int unsigned NUM_CH = 12,
   parameter int unsigned IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_done,
   input  logic [IDX_W-1:0]  win_idx,
   input  logic              win_valid,
   output logic [NUM_CH-1:0] grant,
   output logic [IDX_W-1:0]  grant_idx,
   output logic              busy
);

   logic              decide;
   logic [NUM_CH-1:0] win_onehot;

   assign decide = !busy || blk_done;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      assign win_onehot[c] = win_valid && (win_idx == IDX_W'(c));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant     <= '0;
         grant_idx <= '0;
         busy      <= 1'b0;
      end else if (decide) begin
         grant     <= win_onehot;
         grant_idx <= win_valid ? win_idx : '0;
         busy      <= win_valid;
      end
   end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
   import dma_arb_pkg::*;
#(
   parameter int unsigned NUM_CH     = 12,
   parameter int unsigned PRIO_W     = 2,
   parameter pick_style_e PICK_STYLE = PICK_TREE,
   localparam int unsigned IDX_W = idx_width(NUM_CH),
   localparam int unsigned KEY_W = PRIO_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        req,
   input  logic [NUM_CH-1:0]        en,
   input  logic [NUM_CH*PRIO_W-1:0] prio,
   input  logic                     blk_done,
   output logic [NUM_CH-1:0]        grant,
   output logic [IDX_W-1:0]         grant_idx,
   output logic                     busy
);

   if (NUM_CH < 2 || NUM_CH > 256) begin : g_bad_ch
      $error("dma_prio_arbiter: NUM_CH out of range");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_pw
      $error("dma_prio_arbiter: PRIO_W out of range");
   end

   logic [NUM_CH*KEY_W-1:0] keys;
   logic                    any_elig;
   logic [IDX_W-1:0]        win_idx;
   logic                    win_valid;

   dma_arb_qualify #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_qual (
      .req      (req),
      .en       (en),
      .prio     (prio),
      .keys     (keys),
      .any_elig (any_elig)
   );

   dma_arb_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .PICK_STYLE(PICK_STYLE)) u_pick (
      .keys      (keys),
      .win_idx   (win_idx),
      .win_valid (win_valid)
   );

   dma_arb_hold #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk_done  (blk_done),
      .win_idx   (win_idx),
      .win_valid (win_valid),
      .grant     (grant),
      .grant_idx (grant_idx),
      .busy      (busy)
   );

endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk #(
   parameter int unsigned NUM_CH = 12,
   parameter int unsigned IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] req,
   input logic [NUM_CH-1:0] en,
   input logic              blk_done,
   input logic [NUM_CH-1:0] grant,
   input logic [IDX_W-1:0]  grant_idx,
   input logic              busy
);

   localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

   // R9
   grant_matches_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (grant == (ONE << grant_idx)));

   // R9
   idle_grant_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (grant == '0));

   // R5
   idle_takes_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && |(req & en)) |=> busy);

   // R2
   winner_was_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!busy || blk_done) && |(req & en)) |=> ((grant & $past(req & en)) != '0));

   // R6
   hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !blk_done) |=> ($stable(grant) && $stable(grant_idx)));

   // R8
   release_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && blk_done && !(|(req & en))) |=> !busy);

   // R10
   idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(|(req & en))) |=> !busy);

endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req),
   .en        (en),
   .blk_done  (blk_done),
   .grant     (grant),
   .grant_idx (grant_idx),
   .busy      (busy)
);

// File: tb/dma_prio_arbiter_test.sv
module dma_prio_arbiter_test;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 12;
   localparam int PW  = 2;
   localparam int IW  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH-1:0]    req = '0;
   logic [NCH-1:0]    en = '0;
   logic [NCH*PW-1:0] prio = '0;
   logic              blk_done = 1'b0;
   logic [NCH-1:0]    grant;
   logic [IW-1:0]     grant_idx;
   logic              busy;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_prio_arbiter uut (
      .clk(clk), .rst_n(rst_n), .req(req), .en(en), .prio(prio),
      .blk_done(blk_done), .grant(grant), .grant_idx(grant_idx), .busy(busy)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // model: expected winner (-1 = none)
   function automatic int ref_pick(input logic [NCH-1:0] r, input logic [NCH-1:0] e,
                                   input logic [NCH*PW-1:0] p);
      int best = -1;
      int lvl = -1;
      for (int c = 0; c < NCH; c++) begin
         if (r[c] && e[c] && int'(p[c*PW +: PW]) > lvl) begin
            lvl = int'(p[c*PW +: PW]);
            best = c;
         end
      end
      return best;
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_grant(input string tag, input int exp);
      if (exp < 0) begin
         check({tag, " busy"}, 32'(busy), 0);
         check({tag, " grant"}, 32'(grant), 0);
         check({tag, " idx"}, 32'(grant_idx), 0);
      end else begin
         check({tag, " busy"}, 32'(busy), 1);
         check({tag, " idx"}, 32'(grant_idx), 32'(exp));
         check({tag, " R9 onehot"}, 32'(grant), 32'(1) << exp);
      end
   endtask

   task automatic go_idle();
      req = '0; en = '0; blk_done = busy;
      step();
      blk_done = 1'b0;
   endtask

   task automatic t_reset();
      check_grant("R1 reset", -1);
   endtask

   task automatic t_eligible();
      req = 12'h008; en = 12'h000; prio = '1;
      step();
      check_grant("R2 req without en", -1);
      req = 12'h000; en = 12'h008;
      step();
      check_grant("R2 en without req", -1);
      req = 12'h008;
      step();
      check_grant("R5 idle grant", 3);
      req = '0; blk_done = 1'b1;
      step();
      blk_done = 1'b0;
      check_grant("R8 release", -1);
   endtask

   task automatic t_levels();
      logic [31:0] lf = 32'h1ACE_B00C;
      // ch11 very high vs ch0 low
      en = '1; req = 12'h801; prio = '0; prio[11*PW +: PW] = 2'b11;
      step();
      check_grant("R3 high number wins on level", 11);
      go_idle();
      // all same level: lowest wins
      en = '1; req = 12'hF90; prio = {NCH{2'b10}};
      step();
      check_grant("R4 tie lowest", 4);
      go_idle();
      for (int k = 0; k < 20; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         req = lf[11:0]; en = lf[23:12] | 12'h5A5;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         prio = {lf[23:0]} ^ {lf[7:0], lf[31:16]};
         begin
            int exp_w = ref_pick(req, en, prio);
            step();
            check_grant("R3 R4 pattern", exp_w);
         end
         go_idle();
      end
   endtask

   task automatic t_hold();
      en = '1; req = 12'h024; prio = '0;
      prio[5*PW +: PW] = 2'b10; prio[2*PW +: PW] = 2'b01;
      step();
      check_grant("R3 start hold", 5);
      prio[2*PW +: PW] = 2'b11; req = 12'h004; en = 12'h004;
      for (int k = 0; k < 3; k++) begin
         step();
         check_grant("R6 held", 5);
      end
      blk_done = 1'b1;
      step();
      blk_done = 1'b0;
      check_grant("R7 rearbitrate", 2);
      req = 12'h104; en = '1; prio[8*PW +: PW] = 2'b01; prio[2*PW +: PW] = 2'b11;
      blk_done = 1'b1;
      step();
      blk_done = 1'b0;
      check_grant("R7 same winner again", 2);
      go_idle();
      check_grant("R8 idle after done", -1);
   endtask

   task automatic t_idle_done();
      blk_done = 1'b1;
      step();
      check_grant("R10 done while idle", -1);
      step();
      check_grant("R10 done while idle 2", -1);
      req = 12'h400; en = 12'h400;
      step();
      blk_done = 1'b0;
      check_grant("R10 R5 grant with done high", 10);
      req = 12'h001; en = 12'h001;
      step();
      check_grant("R6 held after idle done", 10);
      go_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_eligible();
      t_levels();
      t_hold();
      t_idle_done();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule